// File: doc/BRIEF.md
# Aperture Remapping Translator

This block maps a fixed window of device-visible addresses onto physical memory, one 4 KiB page at a time. Each page of the window has one 32-bit table entry. Bit 31 of an entry marks it valid, and bits 30:12 give the physical frame that the page lands on. The table is held in flops and sized by the `PAGE_COUNT` parameter. The window starts at `BASE_ADDR`, which must be 4 KiB aligned.

Software reaches the table indirectly through a small 32-bit register port. It first writes the byte address of an aperture page into a selector register. It then reads or writes the entry data register, which acts on the entry for that page. A control register holds the global translation enable. The translation port takes one address per request. One clock later it returns either the remapped physical address or a fault.

Top module: `aperture_remap_xlate`

## Requirements
- R1: After reset, every table entry reads as zero, the control register reads as zero (translation disabled), and `xl_rsp_valid` is low.
- R2: A write to offset 0x0 sets the enable from bit 0 of the write data. A read of offset 0x0 returns the enable in bit 0, with bits 31:1 as zero.
- R3: A write to offset 0x4 stores the full 32-bit page byte address into the selector register, and a read of offset 0x4 returns it unchanged.
- R4: A write to offset 0x8 stores the 32-bit word into entry `(selector - BASE_ADDR) >> 12`. A read of offset 0x8 returns that entry.
- R5: When the selector lies outside the window or has a nonzero value in bits 11:0, an access at offset 0x8 is ignored. A write changes no entry, and a read returns zero.
- R6: For a request that hits, `xl_rsp_valid` is high one cycle after `xl_req` with `xl_rsp_fault` low. The returned address is `{1'b0, entry[30:12], xl_addr[11:0]}`.
- R7: While the enable is 0, every request responds one cycle later with `xl_rsp_fault` high and `xl_rsp_addr` zero.
- R8: An address below `BASE_ADDR`, or at or above `BASE_ADDR + PAGE_COUNT*4096`, faults with `xl_rsp_addr` zero.
- R9: An address whose entry has bit 31 clear faults, whatever the frame bits hold. This includes a page unmapped by writing an all-zero entry.
- R10: Read data appears on `reg_rdata` one cycle after `reg_rd`. A read of any offset other than 0x0, 0x4 or 0x8 returns zero, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ofs | input | 4 | Register byte offset (0x0 control, 0x4 selector, 0x8 entry data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_rd` |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 32 | Address to translate |
| xl_rsp_valid | output | 1 | Translation response valid |
| xl_rsp_fault | output | 1 | Translation failed |
| xl_rsp_addr | output | 32 | Physical address on success, zero on fault |

## Verification
The bench builds the block with `PAGE_COUNT = 12` and `BASE_ADDR = 0x5800_0000`. Because 12 is not a power of two, the window check uses the magnitude-compare variant. The end of the window then falls inside the span that the index bits can address, so page 12 must be rejected by the compare and not by index width. The small table lets the bench program and read back every entry. It also drives the first and last byte of the window and the bytes just outside it on both sides.

// File: rtl/ar_pkg.sv
package ar_pkg;
   localparam int PAGE_SHIFT = 12;
   localparam int FRAME_W    = 32 - PAGE_SHIFT;
   localparam int VALID_BIT  = 31;

   typedef enum logic [3:0] {
      OFS_CTRL  = 4'h0,
      OFS_EADDR = 4'h4,
      OFS_EDATA = 4'h8
   } reg_ofs_e;
endpackage

// File: rtl/ar_window_check.sv
module ar_window_check
   import ar_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
   parameter int          PAGE_COUNT = 16,
   parameter int          IDX_W      = 4
) (
   input  logic [FRAME_W-1:0] page_in,
   output logic               in_win,
   output logic [IDX_W-1:0]   idx
);
   localparam logic [FRAME_W:0] BASE_PG = {1'b0, BASE_ADDR[31:PAGE_SHIFT]};

   logic [FRAME_W:0] rel;
   assign rel = {1'b0, page_in} - BASE_PG;

   generate
      if ((PAGE_COUNT & (PAGE_COUNT - 1)) == 0) begin : g_pow2
         localparam int LOG2 = $clog2(PAGE_COUNT);
         assign in_win = !rel[FRAME_W] && ((rel[FRAME_W-1:0] >> LOG2) == '0);
      end else begin : g_cmp
         assign in_win = !rel[FRAME_W] && (rel[FRAME_W-1:0] < FRAME_W'(PAGE_COUNT));
      end
   endgenerate

   assign idx = rel[IDX_W-1:0];
endmodule

// File: rtl/ar_regfile.sv
module ar_regfile
   import ar_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
   parameter int          PAGE_COUNT = 16,
   parameter int          IDX_W      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [3:0]         reg_ofs,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               xl_en,
   input  logic [IDX_W-1:0]   look_idx,
   output logic [FRAME_W-1:0] look_entry
);
   logic [31:0]           eaddr;
   logic [31:0]           tbl [PAGE_COUNT];
   logic                  win_ok;
   logic                  sel_ok;
   logic [IDX_W-1:0]      sel_idx;
   logic [PAGE_COUNT-1:0] entry_we;

   ar_window_check #(
      .BASE_ADDR (BASE_ADDR),
      .PAGE_COUNT(PAGE_COUNT),
      .IDX_W     (IDX_W)
   ) u_sel_win (
      .page_in(eaddr[31:PAGE_SHIFT]),
      .in_win (win_ok),
      .idx    (sel_idx)
   );

   assign sel_ok = win_ok && (eaddr[PAGE_SHIFT-1:0] == '0);

   for (genvar g = 0; g < PAGE_COUNT; g++) begin : g_we
      assign entry_we[g] = reg_wr && (reg_ofs == OFS_EDATA) && sel_ok
                           && (sel_idx == IDX_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_en     <= 1'b0;
         eaddr     <= '0;
         reg_rdata <= '0;
         for (int i = 0; i < PAGE_COUNT; i++) tbl[i] <= '0;
      end else begin
         if (reg_wr && (reg_ofs == OFS_CTRL))  xl_en <= reg_wdata[0];
         if (reg_wr && (reg_ofs == OFS_EADDR)) eaddr <= reg_wdata;
         for (int i = 0; i < PAGE_COUNT; i++)
            if (entry_we[i]) tbl[i] <= reg_wdata;
         if (reg_rd) begin
            case (reg_ofs)
               OFS_CTRL:  reg_rdata <= {31'd0, xl_en};
               OFS_EADDR: reg_rdata <= eaddr;
               OFS_EDATA: reg_rdata <= sel_ok ? tbl[sel_idx] : '0;
               default:   reg_rdata <= '0;
            endcase
         end
      end
   end

   assign look_entry = tbl[look_idx][31:PAGE_SHIFT];

   // R2: the enable follows bit 0 of a control write
   assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_ofs == OFS_CTRL) |=> (xl_en == $past(reg_wdata[0])));

   // R5: at most one entry is written, and only through a legal selector
   assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(entry_we));

   // R5: a rejected selector reads back as zero
   assert_oob_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_ofs == OFS_EDATA && !sel_ok) |=> (reg_rdata == 32'd0));

   // R10: unmapped offsets read as zero
   assert_bad_ofs_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_ofs != OFS_CTRL && reg_ofs != OFS_EADDR && reg_ofs != OFS_EDATA)
      |=> (reg_rdata == 32'd0));
endmodule

// File: rtl/ar_xlate.sv
module ar_xlate
   import ar_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
   parameter int          PAGE_COUNT = 16,
   parameter int          IDX_W      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               xl_req,
   input  logic [31:0]        xl_addr,
   input  logic               xl_en,
   input  logic [FRAME_W-1:0] look_entry,
   output logic [IDX_W-1:0]   look_idx,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [31:0]        rsp_addr
);
   logic in_win;
   logic hit;

   ar_window_check #(
      .BASE_ADDR (BASE_ADDR),
      .PAGE_COUNT(PAGE_COUNT),
      .IDX_W     (IDX_W)
   ) u_xl_win (
      .page_in(xl_addr[31:PAGE_SHIFT]),
      .in_win (in_win),
      .idx    (look_idx)
   );

   assign hit = xl_en && in_win && look_entry[VALID_BIT-PAGE_SHIFT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= xl_req;
         rsp_fault <= xl_req && !hit;
         rsp_addr  <= (xl_req && hit)
                      ? {1'b0, look_entry[FRAME_W-2:0], xl_addr[PAGE_SHIFT-1:0]}
                      : '0;
      end
   end

   // R6: a successful response keeps the page offset of its request
   assert_offset_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault)
      |-> (rsp_addr[PAGE_SHIFT-1:0] == $past(xl_addr[PAGE_SHIFT-1:0])));

   // R6: every request is answered on the next cycle
   assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xl_req |=> rsp_valid);

   // R7: disabled translation always faults with a zero address
   assert_disabled_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_req && !xl_en) |=> (rsp_valid && rsp_fault && rsp_addr == 32'd0));

   // R8: out-of-window requests fault
   assert_range_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xl_req && !in_win) |=> rsp_fault);
endmodule

// File: rtl/aperture_remap_xlate.sv
module aperture_remap_xlate
   import ar_pkg::*;
#(
   parameter logic [31:0] BASE_ADDR  = 32'h4000_0000,
   parameter int          PAGE_COUNT = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic        reg_rd,
   input  logic [3:0]  reg_ofs,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        xl_req,
   input  logic [31:0] xl_addr,
   output logic        xl_rsp_valid,
   output logic        xl_rsp_fault,
   output logic [31:0] xl_rsp_addr
);
   localparam int IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

   generate
      if (BASE_ADDR[PAGE_SHIFT-1:0] != '0) begin : g_bad_base
         $error("BASE_ADDR must be 4 KiB aligned");
      end
      if (PAGE_COUNT < 1 || PAGE_COUNT > 4096) begin : g_bad_count
         $error("PAGE_COUNT must lie in 1..4096");
      end
   endgenerate

   logic               xl_en;
   logic [IDX_W-1:0]   look_idx;
   logic [FRAME_W-1:0] look_entry;

   ar_regfile #(
      .BASE_ADDR (BASE_ADDR),
      .PAGE_COUNT(PAGE_COUNT),
      .IDX_W     (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_ofs   (reg_ofs),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .xl_en     (xl_en),
      .look_idx  (look_idx),
      .look_entry(look_entry)
   );

   ar_xlate #(
      .BASE_ADDR (BASE_ADDR),
      .PAGE_COUNT(PAGE_COUNT),
      .IDX_W     (IDX_W)
   ) u_xlate (
      .clk       (clk),
      .rst_n     (rst_n),
      .xl_req    (xl_req),
      .xl_addr   (xl_addr),
      .xl_en     (xl_en),
      .look_entry(look_entry),
      .look_idx  (look_idx),
      .rsp_valid (xl_rsp_valid),
      .rsp_fault (xl_rsp_fault),
      .rsp_addr  (xl_rsp_addr)
   );

   // R1: no response without a request in the cycle before
   assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      xl_rsp_valid |-> $past(xl_req));
endmodule

// File: tb/aperture_remap_xlate_tb_top.sv
`timescale 1ns/1ps
module aperture_remap_xlate_tb_top;
   localparam logic [31:0] BASE = 32'h5800_0000;
   localparam int          NPG  = 12;
   localparam logic [31:0] PG   = 32'h0000_1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_ofs = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        xl_req = 1'b0;
   logic [31:0] xl_addr = '0;
   logic        xl_rsp_valid, xl_rsp_fault;
   logic [31:0] xl_rsp_addr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   aperture_remap_xlate #(.BASE_ADDR(BASE), .PAGE_COUNT(NPG)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_ofs(reg_ofs), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xl_req(xl_req), .xl_addr(xl_addr), .xl_rsp_valid(xl_rsp_valid),
      .xl_rsp_fault(xl_rsp_fault), .xl_rsp_addr(xl_rsp_addr)
   );

   function automatic logic [31:0] entry_val(int i);
      return 32'h8000_0000 | ((32'h100 + 32'(i) * 7) << 12) | 32'(i * 3);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] ofs, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_ofs = ofs; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] ofs, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_ofs = ofs;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic xl(input logic [31:0] a, output logic v, output logic f, output logic [31:0] pa);
      @(negedge clk);
      xl_req = 1'b1; xl_addr = a;
      @(negedge clk);
      xl_req = 1'b0;
      v = xl_rsp_valid; f = xl_rsp_fault; pa = xl_rsp_addr;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      logic v, f; logic [31:0] pa;
      chk("R1 rsp_valid after reset", 32'(xl_rsp_valid), 32'd0);
      rd(4'h0, d); chk("R1 control after reset", d, 32'd0);
      wr(4'h4, BASE + 3 * PG);
      rd(4'h8, d); chk("R1 entry after reset", d, 32'd0);
      xl(BASE, v, f, pa);
      chk("R7 disabled valid", 32'(v), 32'd1);
      chk("R7 disabled fault", 32'(f), 32'd1);
      chk("R7 disabled addr", pa, 32'd0);
   endtask

   task automatic t_cfg();
      logic [31:0] d;
      wr(4'h0, 32'd1);          rd(4'h0, d); chk("R2 enable on", d, 32'd1);
      wr(4'h0, 32'hFFFF_FFFE);  rd(4'h0, d); chk("R2 bit0 clear", d, 32'd0);
      wr(4'h0, 32'h0000_0003);  rd(4'h0, d); chk("R2 upper bits read zero", d, 32'd1);
   endtask

   task automatic t_selector();
      logic [31:0] d;
      wr(4'h4, 32'h5800_3000); rd(4'h4, d); chk("R3 selector readback", d, 32'h5800_3000);
      wr(4'h4, 32'hDEAD_BEEF); rd(4'h4, d); chk("R3 selector any value", d, 32'hDEAD_BEEF);
   endtask

   task automatic t_entries();
      logic [31:0] d;
      for (int i = 0; i < NPG; i++) begin
         wr(4'h4, BASE + 32'(i) * PG);
         wr(4'h8, entry_val(i));
      end
      for (int i = NPG - 1; i >= 0; i--) begin
         wr(4'h4, BASE + 32'(i) * PG);
         rd(4'h8, d); chk("R4 entry readback", d, entry_val(i));
      end
   endtask

   task automatic t_hit();
      logic v, f; logic [31:0] pa;
      wr(4'h0, 32'd1);
      for (int i = 0; i < NPG; i += 5) begin
         xl(BASE + 32'(i) * PG + 32'hABC, v, f, pa);
         chk("R6 hit valid", 32'(v), 32'd1);
         chk("R6 hit fault", 32'(f), 32'd0);
         chk("R6 hit addr", pa, ((32'h100 + 32'(i) * 7) << 12) | 32'hABC);
      end
      xl(BASE + 32'(NPG) * PG - 1, v, f, pa);
      chk("R6 last byte fault", 32'(f), 32'd0);
      chk("R6 last byte addr", pa, ((32'h100 + 32'(NPG - 1) * 7) << 12) | 32'hFFF);
   endtask

   task automatic t_range();
      logic v, f; logic [31:0] pa;
      xl(BASE - 1, v, f, pa);
      chk("R8 below base fault", 32'(f), 32'd1); chk("R8 below base addr", pa, 32'd0);
      xl(BASE + 32'(NPG) * PG, v, f, pa);
      chk("R8 past end fault", 32'(f), 32'd1); chk("R8 past end addr", pa, 32'd0);
      xl(32'hFFFF_FFFF, v, f, pa);
      chk("R8 top address fault", 32'(f), 32'd1);
   endtask

   task automatic t_invalid();
      logic v, f; logic [31:0] pa;
      wr(4'h4, BASE + 5 * PG); wr(4'h8, 32'd0);
      xl(BASE + 5 * PG + 32'h10, v, f, pa);
      chk("R9 unmapped fault", 32'(f), 32'd1); chk("R9 unmapped addr", pa, 32'd0);
      wr(4'h4, BASE + 6 * PG); wr(4'h8, 32'h7FFF_F000);
      xl(BASE + 6 * PG, v, f, pa);
      chk("R9 valid bit clear fault", 32'(f), 32'd1);
   endtask

   task automatic t_disable();
      logic v, f; logic [31:0] pa;
      wr(4'h0, 32'd0);
      xl(BASE + 2 * PG, v, f, pa);
      chk("R7 disabled mapped fault", 32'(f), 32'd1); chk("R7 disabled mapped addr", pa, 32'd0);
      wr(4'h0, 32'd1);
      xl(BASE + 2 * PG, v, f, pa);
      chk("R7 re-enabled hit", 32'(f), 32'd0);
   endtask

   task automatic t_ignored();
      logic [31:0] d;
      wr(4'h4, BASE + 32'(NPG) * PG); wr(4'h8, 32'hDEAD_0000);
      rd(4'h8, d); chk("R5 past end read zero", d, 32'd0);
      wr(4'h4, BASE - PG); wr(4'h8, 32'hDEAD_1000);
      rd(4'h8, d); chk("R5 below base read zero", d, 32'd0);
      wr(4'h4, BASE + 2 * PG + 4); wr(4'h8, 32'hDEAD_2000);
      rd(4'h8, d); chk("R5 misaligned read zero", d, 32'd0);
      wr(4'h4, BASE + 2 * PG);
      rd(4'h8, d); chk("R5 entry untouched", d, entry_val(2));
      wr(4'h4, BASE + 11 * PG);
      rd(4'h8, d); chk("R5 last entry untouched", d, entry_val(11));
      wr(4'h4, BASE);
      rd(4'h8, d); chk("R5 first entry untouched", d, entry_val(0));
   endtask

   task automatic t_bad_ofs();
      logic [31:0] d;
      wr(4'h4, BASE + 4 * PG);
      wr(4'hC, 32'h0000_0000);
      wr(4'h1, 32'h0000_0000);
      rd(4'hC, d); chk("R10 unmapped offset reads zero", d, 32'd0);
      rd(4'h0, d); chk("R10 control untouched", d, 32'd1);
      rd(4'h4, d); chk("R10 selector untouched", d, BASE + 4 * PG);
      @(negedge clk);
      reg_rd = 1'b1; reg_ofs = 4'h4;
      @(negedge clk);
      reg_rd = 1'b0;
      chk("R10 read one cycle later", reg_rdata, BASE + 4 * PG);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cfg();
      t_selector();
      t_entries();
      t_hit();
      t_range();
      t_invalid();
      t_disable();
      t_ignored();
      t_bad_ofs();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule